// File: doc/BRIEF.md
# Saturating Vector Narrowing Pack Unit

This block merges two 128-bit source vectors into one 128-bit result whose elements are half the width of the source elements. Each source element is narrowed by one of three rules. The first rule keeps the low half of the element. The second clamps a two's-complement value to the signed range of the narrow width. The third clamps an unsigned value to the unsigned range of the narrow width. Elements are numbered from the most significant end of a vector. The narrowed elements of the first source fill the upper half of the result, and those of the second source fill the lower half.

An operation is requested with a one-cycle `start` pulse. The result, its write enable, the condition code with its strobe, and the specification-error flag all appear on the next clock edge. The result is computed only from the sampled inputs and is committed in a single edge, so the destination can safely be the same register as either source.

In the saturating modes the unit can also report a condition code. This code is derived from how many result elements were clamped.

Top module: `vec_narrow_pack`

## Requirements
- R1: `esize` codes 1, 2 and 3 select 16-, 32- and 64-bit source elements, which narrow to 8, 16 and 32 bits. Element 0 sits at the most significant bits of a vector. Result element i comes from `src_a` element i when i is below 128/source-width, and otherwise from `src_b` element (i - 128/source-width).
- R2: With `mode` 2'b00 (plain pack), each result element is the low half of its source element. Mode 2'b11 behaves the same way.
- R3: With `mode` 2'b01 (signed saturate), the source is read as two's complement. A value above the narrow signed maximum gives that maximum, and a value below the narrow signed minimum gives that minimum. Each clamped element counts as saturated.
- R4: With `mode` 2'b10 (unsigned saturate), the source is read as unsigned. A value above the narrow unsigned maximum gives all ones, and there is no lower clamp.
- R5: When the code is updated, `cc` becomes 3 if every result element saturated, 1 if some but not all saturated, and 0 if none saturated.
- R6: `cc` and the `cc_valid` strobe are updated only for an accepted operation that has `cc_en` high and a saturating mode (01 or 10). In every other case `cc` holds its value and `cc_valid` stays low.
- R7: `esize` code 0 (8-bit source) raises `spec_err` for one cycle, keeps `res_we` low, and leaves `result` and `cc` unchanged. Codes above the 64-bit code cannot be encoded in the 2-bit field.
- R8: After reset, `result` and `cc` are zero and all strobes are low. Outputs respond exactly one cycle after `start`. Without `start`, the strobes stay low and `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle operation request |
| src_a | input | 128 | First source vector, fills the upper half of the result |
| src_b | input | 128 | Second source vector, fills the lower half of the result |
| esize | input | 2 | Source element size code (1=16, 2=32, 3=64 bits) |
| mode | input | 2 | 00 pack, 01 signed saturate, 10 unsigned saturate, 11 pack |
| cc_en | input | 1 | Request a condition-code update in the saturating modes |
| result | output | 128 | Registered narrowed vector |
| res_we | output | 1 | Result was written this cycle |
| cc | output | 2 | Registered condition code |
| cc_valid | output | 1 | Condition code was updated this cycle |
| spec_err | output | 1 | Invalid element size was requested |

## Verification
Each output register is loaded on the edge that follows `start`. A wrong clamp threshold, a swapped source half or a misordered element therefore shows up as a wrong `result` one cycle after the request. A corrupted saturation count shows up in `cc` in that same cycle. A faulty update gate is different: it is only visible later, as a `cc` or `result` that changed when it should have held. For this reason the bench carries its expected `cc` and `result` forward across every operation, including rejected ones and ones without a code update.

// File: rtl/vec_narrow_pack.sv
module vec_narrow_pack #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [1:0]    esize,
  input  logic [1:0]    mode,
  input  logic          cc_en,
  output logic [VW-1:0] result,
  output logic          res_we,
  output logic [1:0]    cc,
  output logic          cc_valid,
  output logic          spec_err
);

  localparam logic [1:0] MD_SS = 2'b01;
  localparam logic [1:0] MD_US = 2'b10;

  logic [2*VW-1:0] cat;
  logic [VW-1:0]   nres_w [1:3];
  logic [3:1]      all_w, any_w;
  logic [VW-1:0]   nres;
  logic            s_all, s_any, bad, sat_mode;
  logic [1:0]      ncc;

  assign cat = {src_a, src_b};

  for (genvar g = 1; g < 4; g++) begin : g_sz
    localparam int SW = 8 << g;
    localparam int NW = SW / 2;
    localparam int N  = 2 * VW / SW;
    logic [N-1:0]  sat;
    logic [VW-1:0] pv;
    for (genvar k = 0; k < N; k++) begin : g_el
      logic [SW-1:0] e;
      logic [NW:0]   top;
      logic          pos, neg, uns;
      assign e   = cat[k*SW +: SW];
      assign top = e[SW-1:NW-1];
      assign pos = !e[SW-1] && |top;
      assign neg = e[SW-1] && !(&top);
      assign uns = |e[SW-1:NW];
      assign sat[k] = (mode == MD_SS && (pos || neg)) || (mode == MD_US && uns);
      assign pv[k*NW +: NW] =
        (mode == MD_SS && pos) ? {1'b0, {(NW-1){1'b1}}} :
        (mode == MD_SS && neg) ? {1'b1, {(NW-1){1'b0}}} :
        (mode == MD_US && uns) ? {NW{1'b1}} : e[NW-1:0];
    end
    assign nres_w[g] = pv;
    assign all_w[g]  = &sat;
    assign any_w[g]  = |sat;
  end

  always_comb begin
    case (esize)
      2'd2:    begin nres = nres_w[2]; s_all = all_w[2]; s_any = any_w[2]; end
      2'd3:    begin nres = nres_w[3]; s_all = all_w[3]; s_any = any_w[3]; end
      default: begin nres = nres_w[1]; s_all = all_w[1]; s_any = any_w[1]; end
    endcase
  end

  assign bad      = (esize == 2'd0);
  assign sat_mode = (mode == MD_SS) || (mode == MD_US);
  assign ncc      = s_all ? 2'd3 : (s_any ? 2'd1 : 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      res_we   <= 1'b0;
      cc       <= 2'd0;
      cc_valid <= 1'b0;
      spec_err <= 1'b0;
    end else begin
      res_we   <= start && !bad;
      spec_err <= start && bad;
      cc_valid <= start && !bad && cc_en && sat_mode;
      if (start && !bad) result <= nres;
      if (start && !bad && cc_en && sat_mode) cc <= ncc;
    end
  end

endmodule

// File: rtl/vec_narrow_pack_chk.sv
module vec_narrow_pack_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   esize,
  input logic [1:0]   mode,
  input logic         cc_en,
  input logic [127:0] result,
  input logic         res_we,
  input logic [1:0]   cc,
  input logic         cc_valid,
  input logic         spec_err
);

  assert_bad_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start && esize == 2'd0 |=> spec_err && !res_we && !cc_valid && $stable(result) && $stable(cc));

  assert_cc_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cc_valid |-> cc != 2'd2);

  assert_cc_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start && (!cc_en || mode == 2'b00 || mode == 2'b11) |=> !cc_valid && $stable(cc));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !res_we && !cc_valid && !spec_err && $stable(result));

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({res_we, spec_err}) <= 1);

endmodule

bind vec_narrow_pack vec_narrow_pack_chk u_chk (.*);

// File: tb/vec_narrow_pack_bench.sv
module vec_narrow_pack_bench;

  typedef struct {
    logic [127:0] res;
    logic         we;
    logic [1:0]   cc;
    logic         ccv;
    logic         err;
  } exp_t;

  logic         clk = 0, rst_n = 0, start = 0, cc_en = 0;
  logic [127:0] src_a = '0, src_b = '0;
  logic [1:0]   esize = 2'd1, mode = 2'd0;
  logic [127:0] result;
  logic         res_we, cc_valid, spec_err;
  logic [1:0]   cc;

  int total = 0, bad = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic [127:0] m_res = '0;
  logic [1:0]   m_cc  = 2'd0;

  always #5 clk = ~clk;

  vec_narrow_pack u_vec_narrow_pack (
    .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
    .esize(esize), .mode(mode), .cc_en(cc_en), .result(result), .res_we(res_we),
    .cc(cc), .cc_valid(cc_valid), .spec_err(spec_err));

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [127:0] ref_pack(input logic [127:0] a, input logic [127:0] b,
                                            input logic [1:0] es, input logic [1:0] md,
                                            output int cnt, output int n);
    int sw, nw;
    logic [255:0] cat;
    logic [127:0] r;
    sw = 8 << es; nw = sw / 2; n = 256 / sw; cat = {a, b}; r = '0; cnt = 0;
    for (int k = 0; k < n; k++) begin
      logic [63:0] u, nv, umax;
      logic signed [63:0] s, smax, smin;
      u = '0;
      for (int j = 0; j < sw; j++) u[j] = cat[k*sw + j];
      s = $signed(u << (64 - sw)) >>> (64 - sw);
      smax = (64'sd1 <<< (nw - 1)) - 64'sd1;
      smin = -smax - 64'sd1;
      umax = (64'd1 << nw) - 64'd1;
      nv = u;
      if (md == 2'b01) begin
        if (s > smax) begin nv = smax; cnt++; end
        else if (s < smin) begin nv = smin; cnt++; end
      end else if (md == 2'b10) begin
        if (u > umax) begin nv = umax; cnt++; end
      end
      for (int j = 0; j < nw; j++) r[k*nw + j] = nv[j];
    end
    return r;
  endfunction

  task automatic drive(input logic [127:0] a, input logic [127:0] b, input logic [1:0] es,
                       input logic [1:0] md, input logic ce, input string tag);
    exp_t e;
    int cnt, n;
    logic [127:0] r;
    logic upd;
    r = ref_pack(a, b, es, md, cnt, n);
    upd = (es != 0) && ce && (md == 2'b01 || md == 2'b10);
    if (es != 0) m_res = r;
    if (upd) m_cc = (cnt == n) ? 2'd3 : (cnt != 0 ? 2'd1 : 2'd0);
    e.res = m_res; e.we = (es != 0); e.cc = m_cc; e.ccv = upd; e.err = (es == 0);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    src_a = a; src_b = b; esize = es; mode = md; cc_en = ce; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  always @(posedge clk) begin
    logic go;
    exp_t e;
    string t;
    go = start;
    #1;
    if (go && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(result === e.res, t, "result", result, e.res);
      check(res_we === e.we && spec_err === e.err, t, "we/err",
            {126'd0, res_we, spec_err}, {126'd0, e.we, e.err});
      check(cc === e.cc && cc_valid === e.ccv, t, "cc/ccv",
            {125'd0, cc, cc_valid}, {125'd0, e.cc, e.ccv});
    end
  end

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(result === '0 && cc === 2'd0 && !res_we && !cc_valid && !spec_err, "R8", "reset",
          {result[123:0], cc, res_we, cc_valid}, '0);

    drive(128'h0001_0002_0003_0004_0005_0006_0007_0008,
          128'h0009_000A_000B_000C_000D_000E_000F_0010, 2'd1, 2'b00, 1'b1, "R1");
    check(result === 128'h0102030405060708090A0B0C0D0E0F10, "R1", "order", result,
          128'h0102030405060708090A0B0C0D0E0F10);
    @(negedge clk);
    check(!res_we && !cc_valid && !spec_err && result === 128'h0102030405060708090A0B0C0D0E0F10,
          "R8", "idle", {125'd0, res_we, cc_valid, spec_err}, '0);

    drive({8{16'h7FFF}}, {8{16'h7FFF}}, 2'd1, 2'b01, 1'b1, "R5_all");
    drive({8{16'h0080}}, {8{16'h0000}}, 2'd1, 2'b01, 1'b1, "R5_some");
    drive({8{16'hFF80}}, {8{16'h007F}}, 2'd1, 2'b01, 1'b1, "R5_none");
    drive({4{32'hFFFF7FFF}}, {4{32'hFFFF8000}}, 2'd2, 2'b01, 1'b1, "R3_min");
    drive({4{32'h00008000}}, {4{32'h80000000}}, 2'd2, 2'b01, 1'b1, "R3");
    drive({64'hFFFFFFFF_FFFFFFFF, 64'h00000000_FFFFFFFF},
          {64'h00000001_00000000, 64'h0}, 2'd3, 2'b10, 1'b1, "R4");
    drive({8{16'h8000}}, {8{16'h00FF}}, 2'd1, 2'b10, 1'b1, "R4_neg");
    drive({8{16'h1234}}, {8{16'hFFFF}}, 2'd1, 2'b00, 1'b1, "R6_pack");
    drive({2{64'h8000000000000000}}, {2{64'h7FFFFFFFFFFFFFFF}}, 2'd3, 2'b01, 1'b1, "R3_64");
    drive({8{16'hFFFF}}, {8{16'hFFFF}}, 2'd1, 2'b10, 1'b0, "R6_noen");
    drive({4{32'hDEADBEEF}}, {4{32'h01234567}}, 2'd2, 2'b11, 1'b1, "R2_m3");
    drive({16{8'h55}}, {16{8'hAA}}, 2'd0, 2'b01, 1'b1, "R7");
    drive({2{64'h1122334455667788}}, {2{64'h99AABBCCDDEEFF00}}, 2'd3, 2'b00, 1'b0, "R2");

    for (int i = 0; i < 80; i++) begin
      logic [127:0] a, b;
      logic [1:0] es, md;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if (i % 3 == 0) begin a = a >> (i % 120); b = ~(b >> (i % 90)); end
      es = 2'(1 + (i % 3));
      md = 2'(i / 3 % 4);
      if (i % 17 == 5) es = 2'd0;
      drive(a, b, es, md, 1'(i % 5 != 0), "R1_R2_R3_R4_rand");
    end

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8", "pending", 128'(exp_q.size()), '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule